// File: doc/BRIEF.md
# LED Blink and Beep Tone Generator

This block makes the slow blink waveforms for four LED-capable GPIO pins and the audible tone for one beep-capable GPIO pin. It also feeds a shared pin that normally carries an active-low interrupt. That pin can instead show an LED blink or a beep tone, but only while the interrupt is asserted (low). Every rate is derived from one free-running timebase. The timebase advances on a `tick` strobe whose rate is 2^SUB_LOG2 ticks per millisecond (8 kHz by default).

Each GPIO channel has a 2-bit rate code. For LEDs the codes give a 2 Hz, 1 Hz or 0.5 Hz square wave. For the beep the codes give a gated or alternating tone. Code 00 leaves the pin to normal GPIO use. The block drives a pin-level signal for each channel and an override enable. The override tells the pad logic to replace the output-register value, and it is raised only when the pin is configured as an output. All outputs are registered, so each output reflects the timebase state and the inputs of the previous clock.

Top module: `led_beep_gen`

## Requirements
- R1: While reset is applied, and through the two-cycle reset release, every pin signal (`led_pin`, `beep_pin`, `shared_pin`) is high and every override enable is low.
- R2: An LED code of 2'b11, 2'b10 or 2'b01 produces a 50% square wave with a period of 500 ms, 1000 ms or 2000 ms. The wave is high in the first half of each period, counted from reset. Code 2'b00 holds the pin high.
- R3: LED channel i takes its code from `led_modes[2i+1:2i]`.
- R4: An override enable is high only when its channel code is nonzero and its `pin_is_input` bit is 0. Bits 0..N_LED-1 of `pin_is_input` belong to the LEDs and bit N_LED to the beep. An input-configured pin still gets its waveform on the pin signal, with the override low.
- R5: Beep code 2'b11 gives a 4 kHz carrier (high on even ticks of each millisecond) during the first 2 ms of every 4 ms window, and high otherwise.
- R6: Beep code 2'b10 gives a 2 kHz carrier (high on ticks 0..1 of every 4) during the first 50 ms of every 100 ms window, and high otherwise.
- R7: Beep code 2'b01 gives a 1 kHz carrier (high on the first half of each ms) in the first half of every second. In the second half it gives 500 Hz (high on even milliseconds).
- R8: Beep code 2'b00 holds `beep_pin` high and its override low.
- R9: `shared_sel` 2'b00 and the reserved 2'b11 pass `int_n` to `shared_pin`. 2'b01 selects the LED wave of `shared_led_mode`. 2'b10 selects the beep wave of `shared_beep_mode`.
- R10: In the LED and beep selections, `shared_pin` is high whenever `int_n` was high, and carries the wave only while `int_n` was low.
- R11: The timebase advances only on cycles with `tick` high. All channels share it, so a code change takes effect at the common phase and disturbs no other channel.
- R12: Every output is registered and reflects the inputs and timebase state of the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase advance strobe, 2^SUB_LOG2 per ms |
| led_modes | input | 2*N_LED | Per-LED 2-bit rate codes |
| beep_mode | input | 2 | Beep tone code |
| pin_is_input | input | N_LED+1 | Direction per channel, 1 = input |
| shared_sel | input | 2 | Shared pin function select |
| shared_led_mode | input | 2 | LED code for the shared pin |
| shared_beep_mode | input | 2 | Beep code for the shared pin |
| int_n | input | 1 | Active-low interrupt request |
| led_pin | output | N_LED | LED pin-level signals |
| led_ovr | output | N_LED | LED override enables |
| beep_pin | output | 1 | Beep pin-level signal |
| beep_ovr | output | 1 | Beep override enable |
| shared_pin | output | 1 | Shared interrupt/LED/beep pin level |

## Verification
Two kinds of event can fall in the same cycle. A change of a rate code or of the shared select can coincide with a timebase step, such as a millisecond or second rollover. A toggle of `int_n` can coincide with a code change that is routed to the shared pin. The bench changes codes, directions, the shared select and `int_n` at intervals that drift against the timebase, with irregular tick gaps, so these events overlap at rollover points. A behavioural model counts ticks and milliseconds as plain integers and predicts every output on every clock. The outputs are judged against that model each cycle, including across a reset applied in the middle of a run.

// File: rtl/lbg_pkg.sv
package lbg_pkg;

  // Phase bits shared by all channels, all produced by one timebase
  typedef struct packed {
    logic c4k;    // 4 kHz carrier
    logic c2k;    // 2 kHz carrier
    logic c1k;    // 1 kHz carrier
    logic c500;   // 500 Hz carrier
    logic g250;   // 250 Hz gate
    logic g10;    // 10 Hz gate
    logic alt1;   // 1 Hz alternation select
    logic led2;   // 2 Hz blink
    logic led1;   // 1 Hz blink
    logic led05;  // 0.5 Hz blink
  } lbg_phase_t;

  typedef enum logic [1:0] {
    SH_INT  = 2'b00,
    SH_LED  = 2'b01,
    SH_BEEP = 2'b10,
    SH_RSVD = 2'b11
  } lbg_shsel_e;

endpackage

// File: rtl/lbg_rst_sync.sv
module lbg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign arst_n = sync_q[1];
endmodule

// File: rtl/lbg_timebase.sv
module lbg_timebase
  import lbg_pkg::*;
#(
  parameter int SUB_LOG2 = 3,
  parameter int MS_PER_S = 1000
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       tick,
  output lbg_phase_t phase
);
  localparam int MS_W = $clog2(MS_PER_S);
  localparam int DEC  = MS_PER_S / 10;
  localparam int DEC_W = $clog2(DEC);
  localparam logic [SUB_LOG2-1:0] SUB_LAST = {SUB_LOG2{1'b1}};
  localparam logic [MS_W-1:0]     MS_LAST  = MS_W'(MS_PER_S - 1);
  localparam logic [MS_W-1:0]     MS_Q1    = MS_W'(MS_PER_S / 4);
  localparam logic [MS_W-1:0]     MS_Q2    = MS_W'(MS_PER_S / 2);
  localparam logic [MS_W-1:0]     MS_Q3    = MS_W'(3 * MS_PER_S / 4);
  localparam logic [DEC_W-1:0]    DEC_LAST = DEC_W'(DEC - 1);
  localparam logic [DEC_W-1:0]    DEC_HALF = DEC_W'(DEC / 2);

  logic [SUB_LOG2-1:0] sub_q, sub_d;
  logic [MS_W-1:0]     ms_q, ms_d;
  logic [DEC_W-1:0]    dec_q, dec_d;
  logic                sec_q, sec_d;
  logic                ms_step;

  always_comb begin
    sub_d   = sub_q;
    ms_d    = ms_q;
    dec_d   = dec_q;
    sec_d   = sec_q;
    ms_step = tick && (sub_q == SUB_LAST);
    if (tick) sub_d = sub_q + 1'b1;
    if (ms_step) begin
      ms_d  = (ms_q == MS_LAST) ? '0 : ms_q + 1'b1;
      dec_d = (dec_q == DEC_LAST) ? '0 : dec_q + 1'b1;
      if (ms_q == MS_LAST) sec_d = ~sec_q;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sub_q <= '0;
      ms_q  <= '0;
      dec_q <= '0;
      sec_q <= 1'b0;
    end else begin
      sub_q <= sub_d;
      ms_q  <= ms_d;
      dec_q <= dec_d;
      sec_q <= sec_d;
    end
  end

  always_comb begin
    phase.c4k   = ~sub_q[SUB_LOG2-3];
    phase.c2k   = ~sub_q[SUB_LOG2-2];
    phase.c1k   = ~sub_q[SUB_LOG2-1];
    phase.c500  = ~ms_q[0];
    phase.g250  = ~ms_q[1];
    phase.g10   = (dec_q < DEC_HALF);
    phase.alt1  = (ms_q < MS_Q2);
    phase.led1  = (ms_q < MS_Q2);
    phase.led2  = (ms_q < MS_Q1) || ((ms_q >= MS_Q2) && (ms_q < MS_Q3));
    phase.led05 = ~sec_q;
  end
endmodule

// File: rtl/lbg_led_chan.sv
module lbg_led_chan
  import lbg_pkg::*;
(
  input  lbg_phase_t phase,
  input  logic [1:0] code,
  output logic       wave
);
  always_comb begin
    unique case (code)
      2'b11:   wave = phase.led2;
      2'b10:   wave = phase.led1;
      2'b01:   wave = phase.led05;
      default: wave = 1'b1;
    endcase
  end
endmodule

// File: rtl/lbg_beep_chan.sv
module lbg_beep_chan
  import lbg_pkg::*;
(
  input  lbg_phase_t phase,
  input  logic [1:0] code,
  output logic       wave
);
  always_comb begin
    unique case (code)
      2'b11:   wave = phase.g250 ? phase.c4k : 1'b1;
      2'b10:   wave = phase.g10  ? phase.c2k : 1'b1;
      2'b01:   wave = phase.alt1 ? phase.c1k : phase.c500;
      default: wave = 1'b1;
    endcase
  end
endmodule

// File: rtl/led_beep_gen.sv
module led_beep_gen
  import lbg_pkg::*;
#(
  parameter int N_LED    = 4,
  parameter int SUB_LOG2 = 3,
  parameter int MS_PER_S = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [2*N_LED-1:0] led_modes,
  input  logic [1:0]         beep_mode,
  input  logic [N_LED:0]     pin_is_input,
  input  logic [1:0]         shared_sel,
  input  logic [1:0]         shared_led_mode,
  input  logic [1:0]         shared_beep_mode,
  input  logic               int_n,
  output logic [N_LED-1:0]   led_pin,
  output logic [N_LED-1:0]   led_ovr,
  output logic               beep_pin,
  output logic               beep_ovr,
  output logic               shared_pin
);
  logic       arst_n;
  lbg_phase_t phase;

  logic [N_LED-1:0] led_wave, led_ovr_d;
  logic             beep_wave, beep_ovr_d;
  logic             sh_led_wave, sh_beep_wave, shared_d;

  lbg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .arst_n(arst_n));

  lbg_timebase #(.SUB_LOG2(SUB_LOG2), .MS_PER_S(MS_PER_S)) u_tb (
    .clk(clk), .arst_n(arst_n), .tick(tick), .phase(phase)
  );

  for (genvar i = 0; i < N_LED; i++) begin : g_led
    lbg_led_chan u_led (.phase(phase), .code(led_modes[2*i +: 2]), .wave(led_wave[i]));
    assign led_ovr_d[i] = (led_modes[2*i +: 2] != 2'b00) && !pin_is_input[i];
  end

  lbg_beep_chan u_beep (.phase(phase), .code(beep_mode), .wave(beep_wave));
  assign beep_ovr_d = (beep_mode != 2'b00) && !pin_is_input[N_LED];

  lbg_led_chan  u_sh_led  (.phase(phase), .code(shared_led_mode),  .wave(sh_led_wave));
  lbg_beep_chan u_sh_beep (.phase(phase), .code(shared_beep_mode), .wave(sh_beep_wave));

  always_comb begin
    unique case (lbg_shsel_e'(shared_sel))
      SH_LED:  shared_d = int_n | sh_led_wave;
      SH_BEEP: shared_d = int_n | sh_beep_wave;
      default: shared_d = int_n;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      led_pin    <= '1;
      led_ovr    <= '0;
      beep_pin   <= 1'b1;
      beep_ovr   <= 1'b0;
      shared_pin <= 1'b1;
    end else begin
      led_pin    <= led_wave;
      led_ovr    <= led_ovr_d;
      beep_pin   <= beep_wave;
      beep_ovr   <= beep_ovr_d;
      shared_pin <= shared_d;
    end
  end
endmodule

// File: rtl/lbg_checker.sv
module lbg_checker #(
  parameter int N_LED = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [2*N_LED-1:0] led_modes,
  input logic [1:0]         beep_mode,
  input logic [N_LED:0]     pin_is_input,
  input logic               int_n,
  input logic [N_LED-1:0]   led_pin,
  input logic [N_LED-1:0]   led_ovr,
  input logic               beep_pin,
  input logic               shared_pin
);
  logic [2:0]       age_q;
  logic             armed;
  logic [N_LED-1:0] idle_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= 3'd0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end
  assign armed = (age_q == 3'd7);

  always_comb begin
    for (int i = 0; i < N_LED; i++) idle_mask[i] = (led_modes[2*i +: 2] == 2'b00);
  end

  assert_led_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((led_pin | ~$past(idle_mask)) == {N_LED{1'b1}}));

  assert_ovr_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((led_ovr & $past(pin_is_input[N_LED-1:0])) == '0));

  assert_beep_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(beep_mode) == 2'b00) |-> beep_pin);

  assert_shared_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(int_n)) |-> shared_pin);

  assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(tick, 2) && ($past(led_modes) == $past(led_modes, 2))) |-> $stable(led_pin));
endmodule

bind led_beep_gen lbg_checker #(.N_LED(N_LED)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .led_modes(led_modes),
  .beep_mode(beep_mode), .pin_is_input(pin_is_input), .int_n(int_n),
  .led_pin(led_pin), .led_ovr(led_ovr), .beep_pin(beep_pin), .shared_pin(shared_pin)
);

// File: tb/led_beep_gen_test.sv
module led_beep_gen_test;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [2*NL-1:0] led_modes = '0;
  logic [1:0]    beep_mode = '0;
  logic [NL:0]   pin_is_input = '1;
  logic [1:0]    shared_sel = '0;
  logic [1:0]    shared_led_mode = '0;
  logic [1:0]    shared_beep_mode = '0;
  logic          int_n = 1'b1;
  logic [NL-1:0] led_pin, led_ovr;
  logic          beep_pin, beep_ovr, shared_pin;

  int n_checks = 0;
  int n_bad = 0;
  int cycles = 0;
  int tick_pct = 100;
  int int_rate = 0;

  always #5 clk = ~clk;

  led_beep_gen uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .led_modes(led_modes),
    .beep_mode(beep_mode), .pin_is_input(pin_is_input), .shared_sel(shared_sel),
    .shared_led_mode(shared_led_mode), .shared_beep_mode(shared_beep_mode),
    .int_n(int_n), .led_pin(led_pin), .led_ovr(led_ovr), .beep_pin(beep_pin),
    .beep_ovr(beep_ovr), .shared_pin(shared_pin)
  );

  // Behavioural reference: tick index within a millisecond, millisecond within two seconds
  int  m_sub = 0;
  int  m_t2 = 0;
  bit  m_s0 = 0, m_s1 = 0;
  logic [NL-1:0] e_led = '1, e_ovr = '0;
  logic e_beep = 1, e_bovr = 0, e_sh = 1;

  function automatic logic led_ref(input logic [1:0] c, input int t2);
    case (c)
      2'b11:   return (t2 % 500) < 250;
      2'b10:   return (t2 % 1000) < 500;
      2'b01:   return t2 < 1000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic beep_ref(input logic [1:0] c, input int sub, input int t2);
    case (c)
      2'b11:   return ((t2 % 4) < 2) ? ((sub % 2) == 0) : 1'b1;
      2'b10:   return ((t2 % 100) < 50) ? ((sub % 4) < 2) : 1'b1;
      2'b01:   return ((t2 % 1000) < 500) ? (sub < 4) : ((t2 % 2) == 0);
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin m_s0 = 0; m_s1 = 0; end
    if (!m_s1) begin
      e_led = '1; e_ovr = '0; e_beep = 1; e_bovr = 0; e_sh = 1;
      m_sub = 0; m_t2 = 0;
    end else begin
      for (int i = 0; i < NL; i++) begin
        e_led[i] = led_ref(led_modes[2*i +: 2], m_t2);
        e_ovr[i] = (led_modes[2*i +: 2] != 0) && !pin_is_input[i];
      end
      e_beep = beep_ref(beep_mode, m_sub, m_t2);
      e_bovr = (beep_mode != 0) && !pin_is_input[NL];
      case (shared_sel)
        2'b01:   e_sh = int_n ? 1'b1 : led_ref(shared_led_mode, m_t2);
        2'b10:   e_sh = int_n ? 1'b1 : beep_ref(shared_beep_mode, m_sub, m_t2);
        default: e_sh = int_n;
      endcase
      if (tick) begin
        if (m_sub == 7) begin m_sub = 0; m_t2 = (m_t2 + 1) % 2000; end
        else m_sub = m_sub + 1;
      end
    end
    if (rst_n) begin m_s1 = m_s0; m_s0 = 1; end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %h expected %h", tag, cycles, got, exp);
    end
  endtask

  // R12: every output compared against the model's registered prediction each cycle
  always @(negedge clk) begin
    cycles++;
    chk("R2 R3 led_pin", 8'(led_pin), 8'(e_led));
    chk("R4 led_ovr", 8'(led_ovr), 8'(e_ovr));
    chk("R5 R6 R7 R8 beep_pin", 8'(beep_pin), 8'(e_beep));
    chk("R4 R8 beep_ovr", 8'(beep_ovr), 8'(e_bovr));
    chk("R9 R10 shared_pin", 8'(shared_pin), 8'(e_sh));
  end

  // Stimulus for tick (R11 gaps) and interrupt toggling
  always @(negedge clk) begin
    #1;
    tick <= ($urandom_range(99) < tick_pct);
    if (int_rate != 0 && $urandom_range(int_rate - 1) == 0) int_n <= ~int_n;
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    // R1: reset values while reset is held
    run(4);
    chk("R1 reset led_pin", 8'(led_pin), 8'h0f);
    chk("R1 reset ovr", 8'({beep_ovr, led_ovr}), 8'h00);
    chk("R1 reset beep/shared", 8'({beep_pin, shared_pin}), 8'h03);
    rst_n = 1'b1;
    run(1);
    chk("R1 release window", 8'({beep_pin, shared_pin, led_pin}), 8'h3f);

    // R2 R3 R4 R5 R9 R10: each LED a different code, shared LED under interrupt
    led_modes = 8'b00_01_10_11;
    pin_is_input = 5'b0_1010;
    beep_mode = 2'b11;
    shared_sel = 2'b01;
    shared_led_mode = 2'b11;
    int_rate = 300;
    run(20000);

    // R6 R9 R11: gapped ticks, beep 10, shared beep alternation
    tick_pct = 70;
    led_modes = 8'b11_10_01_00;
    pin_is_input = 5'b1_0101;
    beep_mode = 2'b10;
    shared_sel = 2'b10;
    shared_beep_mode = 2'b01;
    int_rate = 40;
    run(20000);

    // R7 R9: reserved select passes interrupt, beep 01
    tick_pct = 100;
    beep_mode = 2'b01;
    pin_is_input = 5'b0_0000;
    shared_sel = 2'b11;
    run(18000);

    // R11: codes and select change often, drifting against the timebase
    for (int k = 0; k < 24; k++) begin
      led_modes = 8'($urandom);
      beep_mode = 2'($urandom);
      pin_is_input = 5'($urandom);
      shared_sel = 2'($urandom);
      shared_led_mode = 2'($urandom);
      shared_beep_mode = 2'($urandom);
      tick_pct = (k % 3 == 0) ? 50 : 100;
      run(997 + k * 13);
    end

    // R1: reset applied mid-run, then R8 idle beep
    rst_n = 1'b0;
    run(3);
    chk("R1 mid reset", 8'({beep_ovr, led_ovr}), 8'h00);
    chk("R1 mid reset pins", 8'({beep_pin, shared_pin, led_pin}), 8'h3f);
    rst_n = 1'b1;
    beep_mode = 2'b00;
    shared_sel = 2'b00;
    run(5000);

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    #(10 * 190000);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d: got hang expected finish", cycles);
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule